// File: doc/BRIEF.md
# Event Interrupt Aggregator with Keyed Core Reset

This block sits between a 32-bit register port and a serial peripheral core. It watches seven event lines from the core and latches the rising edge of each line into a sticky status bit. Software clears a status bit by writing a 1 to that bit position, so writing back a value just read clears exactly the bits that were read as set. Each latched bit is masked by a per-source enable bit. The masked result is then gated by a single global enable flag to drive one interrupt line.

A separate reset register lets software restart the core. Only a write of one exact key value produces a one-cycle reset pulse toward the core. Any other value is ignored. The same valid write also empties the status and enable registers, so the restarted core begins with no stale interrupts.

The block uses an asynchronous active-low reset. A two-flop synchronizer inside the block makes reset release synchronous to the clock.

Top module: `evt_irq_ctrl`

## Requirements
- R1: `irq_o` is high exactly when the global enable flag (bit 31 of offset 0x1C) is 1 and at least one source has both its status bit and its enable bit set.
- R2: Status bits live at offset 0x20 bits [6:0], with this mapping: bit 0 mode fault, bit 1 selected as slave while disabled, bit 2 transmit FIFO empty, bit 3 transmit underrun, bit 4 receive full, bit 5 receive overrun, bit 6 transmit half empty. A bit becomes set only on a 0-to-1 transition of `evt_i` for that source. It stays set while the input stays high or falls. A level that is held high does not set the bit again after it has been cleared.
- R3: If a rising edge on an event input and a write-1-to-clear of the same status bit happen in the same cycle, the bit stays set.
- R4: Writing offset 0x20 clears each status bit whose written bit is 1 and leaves unchanged each bit whose written bit is 0. Writing back the value just read clears the register.
- R5: The enable register sits at offset 0x28 bits [6:0]. Writing 0 masks every source, and writes to bits above 6 are dropped. Reads return the stored mask.
- R6: A write of exactly 0x0000000A to offset 0x40 drives `core_rst_o` high for exactly the one cycle after the write. A write of any other value, or a write of 0x0A to any other offset, produces no pulse and changes nothing.
- R7: A valid key write also clears the status and enable registers in the same cycle. The global enable flag is kept.
- R8: After reset, the status, enable and global enable registers read 0, and both `irq_o` and `core_rst_o` are low. Reads of offset 0x40 and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_i | input | 7 | Event lines from the serial core, one per source |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Aggregated interrupt |
| core_rst_o | output | 1 | One-cycle reset pulse toward the serial core |

## Verification
Single-cycle pulses and long held levels on the event lines separate edge detection from level sensing. A held level that survives a clear must not set its bit again. The status register is written with zeros, with partial masks and with the value just read back. Together these show that clearing touches only the bits written as 1. A rising edge that lands on the same cycle as a clear of that bit checks the set-over-clear priority, while a second bit cleared in that same write shows the clear still works for bits without an edge. Near-miss keys show that only the exact value triggers a reset: one differing in a low bit, one differing only in bit 31, and the right value at the wrong offset. A correct key is then written with interrupts armed, to confirm the pulse width and the clearing of status and enable.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  // Register decode result
  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_GIE  = 3'd1,
    SEL_STAT = 3'd2,
    SEL_ENA  = 3'd3,
    SEL_KEY  = 3'd4
  } reg_sel_e;

  // Default register offsets
  localparam int unsigned OFS_GIE_DEF  = 32'h1C;
  localparam int unsigned OFS_STAT_DEF = 32'h20;
  localparam int unsigned OFS_ENA_DEF  = 32'h28;
  localparam int unsigned OFS_KEY_DEF  = 32'h40;
  localparam int unsigned RST_KEY_DEF  = 32'h0A;

  // Source bit positions, as decoded by software
  localparam int unsigned SRC_MODE_FAULT   = 0;
  localparam int unsigned SRC_SLAVE_FAULT  = 1;
  localparam int unsigned SRC_TX_EMPTY     = 2;
  localparam int unsigned SRC_TX_UNDERRUN  = 3;
  localparam int unsigned SRC_RX_FULL      = 4;
  localparam int unsigned SRC_RX_OVERRUN   = 5;
  localparam int unsigned SRC_TX_HALF      = 6;

endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] lvl_q;
  logic [WIDTH-1:0] lvl_n;

  always_comb begin
    lvl_n = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= lvl_n;
    end
  end

  assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] clr_i,
  input  logic             wipe_i,
  output logic [WIDTH-1:0] stat_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic bit_q;
    logic bit_n;

    // Priority: wipe over set over clear
    always_comb begin
      bit_n = bit_q;
      if (clr_i[i]) begin
        bit_n = 1'b0;
      end
      if (rise_i[i]) begin
        bit_n = 1'b1;
      end
      if (wipe_i) begin
        bit_n = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else begin
        bit_q <= bit_n;
      end
    end

    assign stat_o[i] = bit_q;
  end

endmodule

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs #(
  parameter int unsigned WIDTH   = 7,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned RST_KEY = 32'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie_we_i,
  input  logic              ena_we_i,
  input  logic              key_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              gie_o,
  output logic [WIDTH-1:0]  ena_o,
  output logic              key_hit_o,
  output logic              pulse_o
);

  localparam int unsigned GIE_BIT = DATA_W - 1;

  logic             gie_q, gie_n;
  logic [WIDTH-1:0] ena_q, ena_n;
  logic             pulse_q, pulse_n;
  logic             key_hit;

  assign key_hit = key_we_i && (wdata_i == DATA_W'(RST_KEY));

  always_comb begin
    gie_n   = gie_q;
    ena_n   = ena_q;
    pulse_n = 1'b0;
    if (gie_we_i) begin
      gie_n = wdata_i[GIE_BIT];
    end
    if (ena_we_i) begin
      ena_n = wdata_i[WIDTH-1:0];
    end
    if (key_hit) begin
      ena_n   = '0;
      pulse_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      ena_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      gie_q   <= gie_n;
      ena_q   <= ena_n;
      pulse_q <= pulse_n;
    end
  end

  assign gie_o     = gie_q;
  assign ena_o     = ena_q;
  assign key_hit_o = key_hit;
  assign pulse_o   = pulse_q;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 7,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OFS_GIE  = OFS_GIE_DEF,
  parameter int unsigned OFS_STAT = OFS_STAT_DEF,
  parameter int unsigned OFS_ENA  = OFS_ENA_DEF,
  parameter int unsigned OFS_KEY  = OFS_KEY_DEF,
  parameter int unsigned RST_KEY  = RST_KEY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              core_rst_o
);

  localparam int unsigned GIE_BIT = DATA_W - 1;
  localparam int unsigned PAD_W   = DATA_W - NUM_SRC;

  // Reset synchronizer: assert async, release on clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  // Address decode
  reg_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFS_GIE)) begin
      sel = SEL_GIE;
    end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
      sel = SEL_STAT;
    end else if (bus_addr == ADDR_W'(OFS_ENA)) begin
      sel = SEL_ENA;
    end else if (bus_addr == ADDR_W'(OFS_KEY)) begin
      sel = SEL_KEY;
    end
  end

  logic              gie_we, ena_we, key_we, stat_we;
  logic [NUM_SRC-1:0] clr_mask;

  assign gie_we   = bus_wr && (sel == SEL_GIE);
  assign ena_we   = bus_wr && (sel == SEL_ENA);
  assign key_we   = bus_wr && (sel == SEL_KEY);
  assign stat_we  = bus_wr && (sel == SEL_STAT);
  assign clr_mask = stat_we ? bus_wdata[NUM_SRC-1:0] : '0;

  // Datapath
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] ena_q;
  logic               gie_q;
  logic               key_hit;
  logic               pulse;

  evt_edge_det #(
    .WIDTH (NUM_SRC)
  ) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (evt_i),
    .rise_o (rise)
  );

  evt_status_bank #(
    .WIDTH (NUM_SRC)
  ) u_stat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rise_i (rise),
    .clr_i  (clr_mask),
    .wipe_i (key_hit),
    .stat_o (stat_q)
  );

  evt_cfg_regs #(
    .WIDTH   (NUM_SRC),
    .DATA_W  (DATA_W),
    .RST_KEY (RST_KEY)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .gie_we_i  (gie_we),
    .ena_we_i  (ena_we),
    .key_we_i  (key_we),
    .wdata_i   (bus_wdata),
    .gie_o     (gie_q),
    .ena_o     (ena_q),
    .key_hit_o (key_hit),
    .pulse_o   (pulse)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_GIE:  bus_rdata[GIE_BIT] = gie_q;
      SEL_STAT: bus_rdata = {{PAD_W{1'b0}}, stat_q};
      SEL_ENA:  bus_rdata = {{PAD_W{1'b0}}, ena_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_o      = gie_q & (|(stat_q & ena_q));
  assign core_rst_o = pulse;

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC  = 7,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned OFS_STAT = 32'h20,
  parameter int unsigned OFS_KEY  = 32'h40,
  parameter int unsigned RST_KEY  = 32'h0A
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] ena_q,
  input logic               gie_q,
  input logic               irq_o,
  input logic               core_rst_o
);

  logic [NUM_SRC-1:0] evt_prev;
  logic [NUM_SRC-1:0] rise_c;
  logic               stat_wr;
  logic               key_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev <= '0;
    end else begin
      evt_prev <= evt_i;
    end
  end

  assign rise_c  = evt_i & ~evt_prev;
  assign stat_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign key_ok  = bus_wr && (bus_addr == ADDR_W'(OFS_KEY)) &&
                   (bus_wdata == DATA_W'(RST_KEY));

  // R1: no interrupt while the global flag is off
  a_r1_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_o);

  // R1: no interrupt without an enabled pending source
  a_r1_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ena_q) == '0) |-> !irq_o);

  // R2: a status bit only turns on after a rising edge of its input
  a_r2_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(rise_c)) == '0));

  // R3: an edge coinciding with a clear leaves the bit set
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && ((rise_c & bus_wdata[NUM_SRC-1:0]) != '0)) |=>
    ((stat_q & $past(rise_c & bus_wdata[NUM_SRC-1:0])) ==
     $past(rise_c & bus_wdata[NUM_SRC-1:0])));

  // R4: written 1s without a coinciding edge clear their bits
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat_q & $past(bus_wdata[NUM_SRC-1:0] & ~rise_c)) == '0));

  // R6: a pulse is always caused by a valid key write
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> $past(key_ok));

  // R6: without a valid key write there is no pulse next cycle
  a_r6_no_false_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !key_ok |=> !core_rst_o);

  // R7: during the pulse status and enable are empty
  a_r7_wipe: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> ((stat_q == '0) && (ena_q == '0)));

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .NUM_SRC  (NUM_SRC),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .OFS_STAT (OFS_STAT),
  .OFS_KEY  (OFS_KEY),
  .RST_KEY  (RST_KEY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .evt_i      (evt_i),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .stat_q     (stat_q),
  .ena_q      (ena_q),
  .gie_q      (gie_q),
  .irq_o      (irq_o),
  .core_rst_o (core_rst_o)
);

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;

  localparam logic [7:0] A_GIE  = 8'h1C;
  localparam logic [7:0] A_STAT = 8'h20;
  localparam logic [7:0] A_ENA  = 8'h28;
  localparam logic [7:0] A_KEY  = 8'h40;

  logic        clk;
  logic        rst_n;
  logic [6:0]  evt;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        core_rst;

  int n_chk;
  int n_fail;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_o      (irq),
    .core_rst_o (core_rst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Write one register; returns at the falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // One-cycle pulse on the given lines
  task automatic pulse(input logic [6:0] m);
    @(negedge clk);
    evt = evt | m;
    @(negedge clk);
    evt = evt & ~m;
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    rd(A_STAT, v); chk("R8", "status after reset", v, 32'h0);
    rd(A_ENA, v);  chk("R8", "enable after reset", v, 32'h0);
    rd(A_GIE, v);  chk("R8", "global after reset", v, 32'h0);
    rd(A_KEY, v);  chk("R8", "key reg read", v, 32'h0);
    rd(8'h24, v);  chk("R8", "unmapped read", v, 32'h0);
    chk("R8", "irq after reset", {31'b0, irq}, 32'h0);
    chk("R8", "core_rst after reset", {31'b0, core_rst}, 32'h0);
  endtask

  task automatic t_edge_latch;
    logic [31:0] v;
    pulse(7'h04);
    rd(A_STAT, v); chk("R2", "single pulse bit2", v, 32'h04);
    @(negedge clk); evt[5] = 1'b1;
    repeat (3) @(negedge clk);
    rd(A_STAT, v); chk("R2", "held level bit5", v, 32'h24);
    wr(A_STAT, 32'h7F);
    @(negedge clk);
    rd(A_STAT, v); chk("R2", "held level not re-set", v, 32'h0);
    evt[5] = 1'b0;
    @(negedge clk);
    rd(A_STAT, v); chk("R2", "falling edge no set", v, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    pulse(7'h49);
    rd(A_STAT, v); chk("R4", "bits 0,3,6 set", v, 32'h49);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R4", "write zero no change", v, 32'h49);
    wr(A_STAT, 32'h08);
    rd(A_STAT, v); chk("R4", "partial clear", v, 32'h41);
    wr(A_STAT, v);
    rd(A_STAT, v); chk("R4", "write back read value", v, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    pulse(7'h12);
    rd(A_STAT, v); chk("R3", "pre-set bits 1,4", v, 32'h12);
    @(negedge clk);
    evt[1] = 1'b1;
    bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h12;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; evt[1] = 1'b0;
    rd(A_STAT, v); chk("R3", "edge beats clear", v, 32'h02);
    wr(A_STAT, 32'h7F);
    rd(A_STAT, v); chk("R4", "clear after collision", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(A_GIE, 32'h8000_0000);
    pulse(7'h08);
    chk("R5", "masked source no irq", {31'b0, irq}, 32'h0);
    wr(A_ENA, 32'h08);
    chk("R1", "enabled source irq", {31'b0, irq}, 32'h1);
    wr(A_GIE, 32'h0);
    chk("R1", "global off", {31'b0, irq}, 32'h0);
    rd(A_GIE, v); chk("R1", "global readback off", v, 32'h0);
    wr(A_GIE, 32'hFFFF_FFFF);
    chk("R1", "global on", {31'b0, irq}, 32'h1);
    rd(A_GIE, v); chk("R1", "global readback on", v, 32'h8000_0000);
    wr(A_ENA, 32'h0);
    chk("R5", "enable zero masks", {31'b0, irq}, 32'h0);
    rd(A_ENA, v); chk("R5", "enable readback zero", v, 32'h0);
    wr(A_ENA, 32'hFFFF_FFFF);
    rd(A_ENA, v); chk("R5", "upper bits dropped", v, 32'h7F);
    chk("R1", "all enabled irq", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h08);
    chk("R1", "cleared source no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_key_bad;
    logic [31:0] v;
    pulse(7'h01);
    wr(A_KEY, 32'h0B);
    chk("R6", "wrong key low bit", {31'b0, core_rst}, 32'h0);
    wr(A_KEY, 32'h8000_000A);
    chk("R6", "wrong key high bit", {31'b0, core_rst}, 32'h0);
    wr(8'h44, 32'h0A);
    chk("R6", "key wrong offset", {31'b0, core_rst}, 32'h0);
    @(negedge clk);
    chk("R6", "still no pulse", {31'b0, core_rst}, 32'h0);
    rd(A_STAT, v); chk("R6", "status kept", v, 32'h01);
    rd(A_ENA, v);  chk("R6", "enable kept", v, 32'h7F);
  endtask

  task automatic t_key_good;
    logic [31:0] v;
    pulse(7'h60);
    chk("R7", "irq armed before key", {31'b0, irq}, 32'h1);
    wr(A_KEY, 32'h0A);
    chk("R6", "pulse high after key", {31'b0, core_rst}, 32'h1);
    rd(A_STAT, v); chk("R7", "status wiped", v, 32'h0);
    rd(A_ENA, v);  chk("R7", "enable wiped", v, 32'h0);
    rd(A_GIE, v);  chk("R7", "global kept", v, 32'h8000_0000);
    chk("R7", "irq low after key", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R6", "pulse one cycle", {31'b0, core_rst}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; evt = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_edge_latch();
    t_w1c();
    t_collision();
    t_irq();
    t_key_bad();
    t_key_good();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule